// File: doc/BRIEF.md
# Shared Expansion ROM Claim Latch

Many expansion cards can each own a slice of one common 2 KiB ROM window at 0xC800–0xCFFF. Every card sees the same window strobe, so every card needs a small piece of logic that decides whether its ROM answers. This block is that logic. It watches the card's own firmware-page select, the shared window strobe, the address bus and a bus-cycle qualifier. From these it keeps one ownership flag.

A card takes the window when its own firmware page is accessed. Every card gives the window up when the fixed release address 0xCFFF is accessed. Before a driver maps its code in, it touches 0xCFFF, which clears every card. The driver then touches its own firmware page, which sets only its own card. Only one card is mapped at any moment.

The ROM chip-enable is the ownership flag gated by the window strobe. The release access still reads from the owner's ROM in that same cycle. The flag drops only at the end of that cycle.

Top module: `shared_rom_claim`

## Requirements
- R1: Reset is synchronous and active-high. It clears `owner`. While `owner` is 0, `rom_ce` stays 0 even when `win_strobe` is 1. Reset wins over a claim in the same cycle.
- R2: A cycle with `cycle_valid`=1 and `fw_sel`=1 whose address is not 0xCFFF sets `owner`. The new value is visible after the rising edge that ends the cycle.
- R3: `fw_sel` in a cycle with `cycle_valid`=0 does not change `owner`.
- R4: A cycle with `cycle_valid`=1 and `addr`=0xCFFF clears `owner` at the edge that ends the cycle. Any other address does not clear it, and that includes 0xCFFE.
- R5: If one valid cycle has both `addr`=0xCFFF and `fw_sel`=1, the clear wins and `owner` ends up 0.
- R6: `rom_ce` equals `owner` AND `win_strobe` within the same cycle. There is no register between `win_strobe` and `rom_ce`. The 0xCFFF release cycle is therefore still enabled on the card that owned the window.
- R7: Outside R1, R2, R4 and R5, `owner` keeps its value. This covers a 0xCFFF address while `cycle_valid`=0.
- R8: On a shared bus, when drivers follow the rule of releasing first and then claiming, at most one card's `rom_ce` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_valid | input | 1 | Qualifies the current bus cycle |
| fw_sel | input | 1 | This card's own firmware-page select, active high |
| win_strobe | input | 1 | Shared 2 KiB window strobe, active high |
| addr | input | ADDR_W (16) | Bus address |
| rom_ce | output | 1 | Chip-enable for this card's window ROM |
| owner | output | 1 | Ownership flag for the shared window |

## Verification
The bound checker checks these on every cycle:
- Reset clears the flag.
- A qualified claim sets the flag.
- A qualified release clears it, and the release also wins over a simultaneous claim.
- An unqualified cycle leaves the flag unchanged.
- The chip-enable never rises without both the strobe and the flag.

The bench shows what a single card cannot see: three cards on one bus, handing the window over through release and claim sequences, with at most one chip-enable active. It also shows that the owner's chip-enable stays on during the releasing access itself, and that the near-miss address 0xCFFE releases nothing.

// File: rtl/shrom_pkg.sv
package shrom_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam logic [15:0] DEF_REL_ADDR = 16'hCFFF;
  localparam logic [15:0] DEF_REL_MASK = 16'hFFFF;

  typedef enum logic [1:0] {
    OWN_HOLD = 2'd0,
    OWN_SET  = 2'd1,
    OWN_CLR  = 2'd2
  } own_act_e;
endpackage

// File: rtl/shrom_rel_decode.sv
module shrom_rel_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REL_ADDR = 16'hCFFF,
  parameter logic [ADDR_W-1:0] REL_MASK = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_ok;

  // One term per address bit; masked-off bits are left out of the AND.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (REL_MASK[i]) begin : g_cmp
      assign bit_ok[i] = (addr[i] == REL_ADDR[i]);
    end else begin : g_dc
      assign bit_ok[i] = 1'b1;
    end
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/shrom_own_flag.sv
module shrom_own_flag
  import shrom_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cycle_valid,
  input  logic claim,
  input  logic rel_hit,
  output logic owner_q
);
  own_act_e act;

  // Release outranks claim; nothing happens without a qualified cycle.
  always_comb begin
    act = OWN_HOLD;
    if (cycle_valid) begin
      if (rel_hit)    act = OWN_CLR;
      else if (claim) act = OWN_SET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= 1'b0;
    end else begin
      unique case (act)
        OWN_SET:  owner_q <= 1'b1;
        OWN_CLR:  owner_q <= 1'b0;
        default:  owner_q <= owner_q;
      endcase
    end
  end
endmodule

// File: rtl/shrom_ce_gate.sv
module shrom_ce_gate (
  input  logic owner_q,
  input  logic win_strobe,
  output logic rom_ce
);
  // Same-cycle gate: the strobe reaches the ROM with no register in the path.
  assign rom_ce = owner_q & win_strobe;
endmodule

// File: rtl/shared_rom_claim.sv
module shared_rom_claim
  import shrom_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] REL_ADDR = DEF_REL_ADDR,
  parameter logic [ADDR_W-1:0] REL_MASK = DEF_REL_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_valid,
  input  logic              fw_sel,
  input  logic              win_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_ce,
  output logic              owner
);
  logic rel_hit;
  logic owner_q;

  shrom_rel_decode #(
    .ADDR_W  (ADDR_W),
    .REL_ADDR(REL_ADDR),
    .REL_MASK(REL_MASK)
  ) u_dec (
    .addr(addr),
    .hit (rel_hit)
  );

  shrom_own_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .cycle_valid(cycle_valid),
    .claim      (fw_sel),
    .rel_hit    (rel_hit),
    .owner_q    (owner_q)
  );

  shrom_ce_gate u_gate (
    .owner_q   (owner_q),
    .win_strobe(win_strobe),
    .rom_ce    (rom_ce)
  );

  assign owner = owner_q;
endmodule

// File: rtl/shared_rom_claim_chk.sv
module shared_rom_claim_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REL_ADDR = 16'hCFFF,
  parameter logic [ADDR_W-1:0] REL_MASK = 16'hFFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              cycle_valid,
  input logic              fw_sel,
  input logic              win_strobe,
  input logic [ADDR_W-1:0] addr,
  input logic              rom_ce,
  input logic              owner
);
  logic at_rel;
  assign at_rel = (((addr ^ REL_ADDR) & REL_MASK) == '0);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !owner); // R1
  AST_CLAIM_SETS: assert property (@(posedge clk) disable iff (rst)
    (cycle_valid && fw_sel && !at_rel) |=> owner); // R2
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cycle_valid && at_rel) |=> !owner); // R4
  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (rst)
    (cycle_valid && at_rel && fw_sel) |=> !owner); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cycle_valid |=> $stable(owner)); // R3
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!owner && !(cycle_valid && fw_sel)) |=> !owner); // R7
  AST_CE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    rom_ce |-> win_strobe); // R6
  AST_CE_NEEDS_OWNER: assert property (@(posedge clk) disable iff (rst)
    rom_ce |-> owner); // R6
endmodule

bind shared_rom_claim shared_rom_claim_chk #(
  .ADDR_W  (ADDR_W),
  .REL_ADDR(REL_ADDR),
  .REL_MASK(REL_MASK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cycle_valid(cycle_valid),
  .fw_sel     (fw_sel),
  .win_strobe (win_strobe),
  .addr       (addr),
  .rom_ce     (rom_ce),
  .owner      (owner)
);

// File: tb/shared_rom_claim_tb_top.sv
module shared_rom_claim_tb_top;
  localparam int NCARD = 3;

  typedef struct packed {
    logic        v;
    logic [15:0] a;
    logic [2:0]  ce;
    logic [2:0]  own;
  } vec_t;

  // The card in slot k (k = 0..2) has its firmware page at 0xC(k+1)00.
  // The ce column is the value expected during the cycle.
  // The own column is the value expected after the edge that ends the cycle.
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 16'hC100, 3'b000, 3'b001},  // R2 card0 claims
    '{1'b1, 16'hC800, 3'b001, 3'b001},  // R6 window read
    '{1'b1, 16'hCFFF, 3'b001, 3'b000},  // R4 R6 release still enabled
    '{1'b1, 16'hC900, 3'b000, 3'b000},  // R6 nobody owns
    '{1'b1, 16'hC200, 3'b000, 3'b010},  // R2 card1 claims
    '{1'b1, 16'hCA00, 3'b010, 3'b010},  // R6
    '{1'b0, 16'hC300, 3'b000, 3'b010},  // R3 unqualified claim
    '{1'b1, 16'h0400, 3'b000, 3'b010},  // R7 unrelated access
    '{1'b1, 16'hCFFF, 3'b010, 3'b000},  // R4
    '{1'b1, 16'hC300, 3'b000, 3'b100},  // R2 card2 claims
    '{1'b1, 16'hCFFE, 3'b100, 3'b100},  // R4 near miss
    '{1'b0, 16'hCFFF, 3'b000, 3'b100},  // R7 unqualified release
    '{1'b1, 16'hCFFF, 3'b100, 3'b000}   // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_valid = 1'b0;
  logic win_strobe = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [NCARD-1:0] fw_sel = '0;
  logic [NCARD-1:0] rom_ce;
  logic [NCARD-1:0] owner;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  for (genvar k = 0; k < NCARD; k++) begin : g_card
    if (k == 0) begin : g_dut
      shared_rom_claim dut_i (
        .clk(clk), .rst(rst), .cycle_valid(cycle_valid), .fw_sel(fw_sel[k]),
        .win_strobe(win_strobe), .addr(addr), .rom_ce(rom_ce[k]), .owner(owner[k]));
    end else begin : g_peer
      shared_rom_claim u_card (
        .clk(clk), .rst(rst), .cycle_valid(cycle_valid), .fw_sel(fw_sel[k]),
        .win_strobe(win_strobe), .addr(addr), .rom_ce(rom_ce[k]), .owner(owner[k]));
    end
  end

  function automatic logic [NCARD-1:0] host_fw(input logic v, input logic [15:0] a);
    logic [NCARD-1:0] f;
    for (int k = 0; k < NCARD; k++) f[k] = v && (a[15:8] == 8'hC1 + 8'(k));
    return f;
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, then check the same-cycle chip-enables.
  task automatic drive(input logic v, input logic [15:0] a, input logic [2:0] fw,
                       input logic [2:0] exp_ce, input string tag);
    @(negedge clk);
    cycle_valid = v;
    addr = a;
    fw_sel = fw;
    win_strobe = v && (a >= 16'hC800);
    #5;
    chk({tag, " ce"}, rom_ce, exp_ce);
    checks++;  // R8 single window owner
    if ($countones(rom_ce) > 1) begin
      failures++;
      $display("FAIL R8 actual=%b expected=at most one bit", rom_ce);
    end
  endtask

  task automatic after_edge(input logic [2:0] exp_own, input string tag);
    @(posedge clk);
    #1;
    chk({tag, " owner"}, owner, exp_own);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    drive(1'b1, 16'hC800, 3'b000, 3'b000, "R1 reset-held");
    after_edge(3'b000, "R1 reset");
    rst = 1'b0;
    drive(1'b1, 16'hCC00, 3'b000, 3'b000, "R1 after reset");
    after_edge(3'b000, "R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].v, VEC[i].a, host_fw(VEC[i].v, VEC[i].a), VEC[i].ce,
            $sformatf("vec%0d", i));
      after_edge(VEC[i].own, $sformatf("vec%0d", i));
    end

    // R5: a release and a claim in the same cycle
    drive(1'b1, 16'hCFFF, 3'b011, 3'b000, "R5");
    after_edge(3'b000, "R5 release wins");
    // R3: all selects raised without a qualified cycle
    drive(1'b0, 16'hC100, 3'b111, 3'b000, "R3");
    after_edge(3'b000, "R3 no claim");
    // R1: reset wins over a claim in the same cycle
    drive(1'b1, 16'hC200, host_fw(1'b1, 16'hC200), 3'b000, "R2 claim");
    after_edge(3'b010, "R2 claim");
    drive(1'b1, 16'hCB00, 3'b000, 3'b010, "R6 owner read");
    rst = 1'b1;
    after_edge(3'b000, "R1 mid-run reset");
    drive(1'b1, 16'hC100, host_fw(1'b1, 16'hC100), 3'b000, "R1 claim in reset");
    after_edge(3'b000, "R1 claim in reset");
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule